// File: doc/BRIEF.md
# GPIO Port Interrupt Unit

This block watches the input pins of one GPIO port, up to 32 of them, and raises a single interrupt line for the port. Software reaches it through a small memory-mapped register interface. The interface has an address, write data, a write strobe, a read strobe and read data. Read data is combinational and valid in the same cycle as the read strobe.

Every pin takes a 2-bit trigger code. The code selects high level, low level, rising edge or falling edge. The codes live in two type words. Each pin input passes through a two-flop synchronizer. A third flop keeps the previous synchronized value, which edge detection uses. A pin that triggers sets its bit in a pending register, and software clears that bit by writing 1 to it. The port interrupt is high when the port enable bit is set and at least one pending pin is also set in the mask register. A status bit in the control register records that the interrupt condition has occurred until software acknowledges it.

A port may implement fewer pins than the register width. The count is a parameter, and the unused upper pins never trigger. The register offsets are parameters; the defaults are control 0x204, pending 0x208, mask 0x20C and type base 0x240.

Top module: `gpio_port_irq`

## Requirements
- R1: After reset, the control, pending, mask and both type words read 0, and `irq_o` is 0.
- R2: Trigger code 2 (rising edge) sets the pin's pending bit once for each 0-to-1 transition of the synchronized pin. A pin that stays high or falls sets nothing.
- R3: Trigger code 3 (falling edge) sets the pin's pending bit once for each 1-to-0 transition. A pin that stays low or rises sets nothing.
- R4: Trigger code 0 (level high) and code 1 (level low) set the pending bit on every cycle the level holds. A write-1 clear in such a cycle leaves the bit at 1.
- R5: Pins 0 to 15 take their codes from the word at type base + 4, and pins 16 to 31 from the word at type base + 0. A pin's field starts at bit (pin mod 16) x 2. Both words read back as written.
- R6: A pending bit is cleared only by writing 1 to it at the pending offset. Writing 0 leaves it unchanged.
- R7: A pending pin contributes to `irq_o` only when its bit in the mask register (bit n = pin n) is 1.
- R8: `irq_o` is 1 exactly when control bit 1 (port enable) is 1 and pending AND mask is nonzero.
- R9: Control bit 0 reads 1 from the cycle after `irq_o` is 1 until software writes 1 to control bit 0. An acknowledge in a cycle where `irq_o` is still 1 does not clear it.
- R10: Control bit 2 (sample-clock select) is stored and read back, and it does not change trigger detection.
- R11: Pins at or above `PORT_PINS` never set pending. Their mask bits read 0.
- R12: A pin change applied before a clock edge appears in the pending register after the third rising edge: two synchronizer edges, then the pending register edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 32 | Asynchronous pin inputs |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, combinational, 0 when not reading |
| irq_o | output | 1 | Port interrupt request |

## Verification
Assertions check on every cycle the following properties:
- a rising-edge trigger fires for only one cycle;
- every trigger lands in the pending register on the next edge;
- a write-1 clear removes every bit that is not re-triggered in the same cycle;
- pending bits never drop without such a write;
- the status bit follows the interrupt.

Only the bench scenarios can show the rest:
- the trigger code decode for each code on pins in both type words;
- the pending latency in cycles;
- the gating of the interrupt by mask and enable;
- the acknowledge sequence;
- the pins above the count that stay silent;
- the return to zero after a reset in the middle of a run.

// File: rtl/gpio_irq_pkg.sv
// Shared definitions for the GPIO port interrupt unit.
// Assumes a 32-bit register data path with one bit per pin.
package gpio_irq_pkg;
    localparam int REG_W   = 32;
    localparam int CODE_W  = 2;
    localparam int HALF_PINS = REG_W / CODE_W;

    // Per-pin trigger selection codes
    typedef enum logic [CODE_W-1:0] {
        TRIG_LVL_HI = 2'd0,
        TRIG_LVL_LO = 2'd1,
        TRIG_RISE   = 2'd2,
        TRIG_FALL   = 2'd3
    } trig_e;

    // Bit positions inside the control word
    localparam int CTRL_ACK_BIT    = 0;
    localparam int CTRL_EN_BIT     = 1;
    localparam int CTRL_CLKSEL_BIT = 2;
endpackage

// File: rtl/gpio_irq_sync.sv
// Two-flop synchronizer for every pin, plus one history flop.
// Provides the current and previous synchronized value for edge detection.
// Assumes pins are asynchronous and glitches shorter than a cycle may be lost.
module gpio_irq_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] hist_q;

    // Synchronize pins and keep one cycle of history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign cur_o  = sync_q;
    assign prev_o = hist_q;
endmodule

// File: rtl/gpio_irq_detect.sv
// Per-pin trigger decode: level high, level low, rising edge, falling edge.
// Produces a one-cycle hit vector, forced to zero for pins at or above ACTIVE.
// Assumes cur/prev come from the synchronizer and codes are stable registers.
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int W      = 32,
    parameter int ACTIVE = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      cur_i,
    input  logic [W-1:0]      prev_i,
    input  logic [2*W-1:0]    codes_i,
    output logic [W-1:0]      hit_o
);
    localparam logic [W-1:0] VALID = W'((64'd1 << ACTIVE) - 64'd1);

    logic [W-1:0] hit_raw;

    for (genvar i = 0; i < W; i++) begin : g_pin
        trig_e code;
        assign code = trig_e'(codes_i[CODE_W*i +: CODE_W]);

        // Decode the pin's trigger condition from its code
        always_comb begin
            unique case (code)
                TRIG_LVL_HI: hit_raw[i] = cur_i[i];
                TRIG_LVL_LO: hit_raw[i] = !cur_i[i];
                TRIG_RISE:   hit_raw[i] = cur_i[i] && !prev_i[i];
                TRIG_FALL:   hit_raw[i] = !cur_i[i] && prev_i[i];
                default:     hit_raw[i] = 1'b0;
            endcase
        end

        // R2: a rising-edge trigger never fires two cycles in a row
        p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_raw[i] && code == TRIG_RISE && $past(code) == TRIG_RISE)
                |-> !$past(hit_raw[i]));
    end

    assign hit_o = hit_raw & VALID;
endmodule

// File: rtl/gpio_irq_regs.sv
// Register file: control, pending (write-1-clear), mask and two type words.
// Builds the port interrupt and the latched port status bit.
// Assumes single-cycle write strobes. Reads are combinational while reg_re is high.
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int W                 = 32,
    parameter int ACTIVE            = 32,
    parameter int ADDR_W            = 12,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 12'h204,
    parameter logic [ADDR_W-1:0] PEND_OFS = 12'h208,
    parameter logic [ADDR_W-1:0] MASK_OFS = 12'h20C,
    parameter logic [ADDR_W-1:0] TYPE_OFS = 12'h240
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [W-1:0]      wdata_i,
    input  logic              we_i,
    input  logic              re_i,
    output logic [W-1:0]      rdata_o,
    input  logic [W-1:0]      hit_i,
    output logic [2*W-1:0]    codes_o,
    output logic              irq_o
);
    localparam logic [W-1:0] VALID = W'((64'd1 << ACTIVE) - 64'd1);
    localparam logic [ADDR_W-1:0] TYPE_HI_OFS = TYPE_OFS;
    localparam logic [ADDR_W-1:0] TYPE_LO_OFS = TYPE_OFS + ADDR_W'(4);

    logic [W-1:0] pend_q, mask_q, type_lo_q, type_hi_q;
    logic         en_q, clksel_q, stat_q;
    logic         sel_ctrl, sel_pend, sel_mask, sel_tlo, sel_thi;
    logic [W-1:0] clr_vec, pend_nxt;
    logic         cond, ack, stat_nxt;

    // Address decode of the five registers
    always_comb begin
        sel_ctrl = (addr_i == CTRL_OFS);
        sel_pend = (addr_i == PEND_OFS);
        sel_mask = (addr_i == MASK_OFS);
        sel_tlo  = (addr_i == TYPE_LO_OFS);
        sel_thi  = (addr_i == TYPE_HI_OFS);
    end

    // Next pending value: clear first, new triggers win
    always_comb begin
        clr_vec  = (we_i && sel_pend) ? wdata_i : '0;
        pend_nxt = ((pend_q & ~clr_vec) | hit_i) & VALID;
    end

    // Port interrupt condition and status latch update
    always_comb begin
        cond     = en_q && |(pend_q & mask_q);
        ack      = we_i && sel_ctrl && wdata_i[CTRL_ACK_BIT];
        stat_nxt = (stat_q && !ack) || cond;
    end

    // Register storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= '0;
            mask_q    <= '0;
            type_lo_q <= '0;
            type_hi_q <= '0;
            en_q      <= 1'b0;
            clksel_q  <= 1'b0;
            stat_q    <= 1'b0;
        end else begin
            pend_q <= pend_nxt;
            stat_q <= stat_nxt;
            if (we_i && sel_mask) mask_q    <= wdata_i & VALID;
            if (we_i && sel_tlo)  type_lo_q <= wdata_i;
            if (we_i && sel_thi)  type_hi_q <= wdata_i;
            if (we_i && sel_ctrl) begin
                en_q     <= wdata_i[CTRL_EN_BIT];
                clksel_q <= wdata_i[CTRL_CLKSEL_BIT];
            end
        end
    end

    // Read multiplexer
    always_comb begin
        rdata_o = '0;
        if (re_i) begin
            if (sel_ctrl) begin
                rdata_o[CTRL_ACK_BIT]    = stat_q;
                rdata_o[CTRL_EN_BIT]     = en_q;
                rdata_o[CTRL_CLKSEL_BIT] = clksel_q;
            end
            if (sel_pend) rdata_o = pend_q;
            if (sel_mask) rdata_o = mask_q;
            if (sel_tlo)  rdata_o = type_lo_q;
            if (sel_thi)  rdata_o = type_hi_q;
        end
    end

    // Low pins live in the low word, high pins in the high word
    assign codes_o = {type_hi_q, type_lo_q};
    assign irq_o   = cond;

    // R6: a write-1 clear removes every bit not re-triggered that cycle
    p_clear_takes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_pend) |=> ((pend_q & $past(wdata_i & ~hit_i)) == '0));

    // R6: without a pending write, no pending bit falls
    p_no_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i && sel_pend) |=> (($past(pend_q) & ~pend_q) == '0));

    // R4: every trigger is in the pending register one edge later
    p_hit_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit_i) |=> ((pend_q & $past(hit_i)) == $past(hit_i)));

    // R9: the status bit is set after any cycle with the interrupt high
    p_stat_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> stat_q);
endmodule

// File: rtl/gpio_port_irq.sv
// GPIO port interrupt unit top: synchronizer, trigger decode, registers.
// Assumes PORT_PINS <= 32 and a register bus with single-cycle strobes.
module gpio_port_irq
    import gpio_irq_pkg::*;
#(
    parameter int PORT_PINS = 30,
    parameter int ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 12'h204,
    parameter logic [ADDR_W-1:0] PEND_OFS = 12'h208,
    parameter logic [ADDR_W-1:0] MASK_OFS = 12'h20C,
    parameter logic [ADDR_W-1:0] TYPE_OFS = 12'h240
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  pin_i,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              reg_we,
    input  logic              reg_re,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq_o
);
    logic [REG_W-1:0]   cur, prev, hit;
    logic [2*REG_W-1:0] codes;

    gpio_irq_sync #(.W(REG_W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .cur_o  (cur),
        .prev_o (prev)
    );

    gpio_irq_detect #(.W(REG_W), .ACTIVE(PORT_PINS)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .cur_i   (cur),
        .prev_i  (prev),
        .codes_i (codes),
        .hit_o   (hit)
    );

    gpio_irq_regs #(
        .W        (REG_W),
        .ACTIVE   (PORT_PINS),
        .ADDR_W   (ADDR_W),
        .CTRL_OFS (CTRL_OFS),
        .PEND_OFS (PEND_OFS),
        .MASK_OFS (MASK_OFS),
        .TYPE_OFS (TYPE_OFS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .we_i    (reg_we),
        .re_i    (reg_re),
        .rdata_o (reg_rdata),
        .hit_i   (hit),
        .codes_o (codes),
        .irq_o   (irq_o)
    );
endmodule

// File: tb/sim_gpio_port_irq.sv
`timescale 1ns/1ps
module sim_gpio_port_irq;
    localparam logic [11:0] A_CTRL = 12'h204;
    localparam logic [11:0] A_PEND = 12'h208;
    localparam logic [11:0] A_MASK = 12'h20C;
    localparam logic [11:0] A_THI  = 12'h240;
    localparam logic [11:0] A_TLO  = 12'h244;
    localparam int NVEC = 12;
    // {pin[4:0], code[1:0], start level, end level, expected pending}
    localparam logic [9:0] VEC [NVEC] = '{
        {5'd0,  2'd2, 1'b0, 1'b1, 1'b1},   // R2 rise
        {5'd0,  2'd2, 1'b1, 1'b0, 1'b0},   // R2 fall ignored
        {5'd1,  2'd2, 1'b1, 1'b1, 1'b0},   // R2 held high
        {5'd7,  2'd3, 1'b1, 1'b0, 1'b1},   // R3 fall
        {5'd7,  2'd3, 1'b0, 1'b1, 1'b0},   // R3 rise ignored
        {5'd12, 2'd3, 1'b1, 1'b0, 1'b1},   // R3
        {5'd15, 2'd0, 1'b0, 1'b1, 1'b1},   // R4 level high, R5 top of low word
        {5'd20, 2'd0, 1'b0, 1'b0, 1'b0},   // R4 inactive level
        {5'd16, 2'd1, 1'b1, 1'b0, 1'b1},   // R4 level low, R5 bottom of high word
        {5'd16, 2'd1, 1'b0, 1'b1, 1'b1},   // R4 clear did not stick
        {5'd29, 2'd2, 1'b0, 1'b1, 1'b1},   // R5 last implemented pin
        {5'd30, 2'd0, 1'b0, 1'b1, 1'b0}    // R11 unimplemented pin
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic        re = 1'b0;
    logic [31:0] rdata;
    logic        irq;
    logic [63:0] tshadow = '0;
    logic [31:0] rv;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_port_irq u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pins),
        .reg_addr  (addr),
        .reg_wdata (wdata),
        .reg_we    (we),
        .reg_re    (re),
        .reg_rdata (rdata),
        .irq_o     (irq)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a; re = 1'b1;
        #1 d = rdata;
        re = 1'b0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_code(input int p, input logic [1:0] c);
        tshadow[2*p +: 2] = c;
        wr(A_TLO, tshadow[31:0]);
        wr(A_THI, tshadow[63:32]);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1: reset state
        rd(A_CTRL, rv); chk("R1 ctrl", rv, 32'h0);
        rd(A_PEND, rv); chk("R1 pend", rv, 32'h0);
        rd(A_MASK, rv); chk("R1 mask", rv, 32'h0);
        rd(A_TLO, rv);  chk("R1 type lo", rv, 32'h0);
        rd(A_THI, rv);  chk("R1 type hi", rv, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // Vector table walk
        for (int k = 0; k < NVEC; k++) begin
            automatic logic [9:0] v = VEC[k];
            automatic int p = int'(v[9:5]);
            set_code(p, v[4:3]);
            pins[p] = v[2];
            cyc(5);
            wr(A_PEND, 32'hFFFF_FFFF);
            pins[p] = v[1];
            cyc(5);
            rd(A_PEND, rv);
            chk($sformatf("R2/R3/R4/R5/R11 vector %0d", k), (rv >> p) & 32'h1, {31'b0, v[0]});
            pins[p] = 1'b0;
            cyc(5);
            set_code(p, 2'd0);
            wr(A_PEND, 32'hFFFF_FFFF);
            rd(A_PEND, rv); chk("R6 cleanup clear", rv, 32'h0);
        end

        // R12: latency of three edges
        set_code(3, 2'd2);
        pins[3] = 1'b1;
        cyc(2);
        rd(A_PEND, rv); chk("R12 not before third edge", rv & 32'h8, 32'h0);
        cyc(1);
        rd(A_PEND, rv); chk("R12 at third edge", rv & 32'h8, 32'h8);

        // R7/R8: mask and enable gating
        wr(A_MASK, 32'h0);
        wr(A_CTRL, 32'h2);
        chk("R7 masked out", {31'b0, irq}, 32'h0);
        wr(A_MASK, 32'h8);
        chk("R7 masked in", {31'b0, irq}, 32'h1);
        wr(A_CTRL, 32'h0);
        chk("R8 disabled", {31'b0, irq}, 32'h0);
        wr(A_CTRL, 32'h2);
        chk("R8 enabled", {31'b0, irq}, 32'h1);
        cyc(1);
        rd(A_CTRL, rv); chk("R9 status set", rv, 32'h3);
        wr(A_PEND, 32'h8);
        chk("R6 clear drops irq", {31'b0, irq}, 32'h0);
        rd(A_CTRL, rv); chk("R9 status held", rv, 32'h3);
        wr(A_CTRL, 32'h3);
        rd(A_CTRL, rv); chk("R9 acknowledged", rv, 32'h2);

        // R4/R9: level trigger keeps pending and status
        set_code(3, 2'd0);
        cyc(1);
        wr(A_CTRL, 32'h3);
        rd(A_CTRL, rv); chk("R9 ack while active", rv, 32'h3);
        wr(A_PEND, 32'h8);
        rd(A_PEND, rv); chk("R4 clear does not stick", rv & 32'h8, 32'h8);

        // R6: writing zero keeps pending
        set_code(3, 2'd2);
        pins[3] = 1'b0;
        cyc(4);
        wr(A_PEND, 32'hFFFF_FFFF);
        wr(A_CTRL, 32'h3);
        pins[3] = 1'b1;
        cyc(4);
        wr(A_PEND, 32'h0);
        rd(A_PEND, rv); chk("R6 write zero", rv, 32'h8);
        wr(A_PEND, 32'h8);
        rd(A_PEND, rv); chk("R6 write one", rv, 32'h0);

        // R10: clock select stored and harmless
        cyc(1);
        wr(A_CTRL, 32'h3);
        wr(A_CTRL, 32'h6);
        rd(A_CTRL, rv); chk("R10 readback", rv, 32'h6);
        pins[3] = 1'b0;
        cyc(4);
        pins[3] = 1'b1;
        cyc(4);
        rd(A_PEND, rv); chk("R10 detection unchanged", rv, 32'h8);
        chk("R10 irq", {31'b0, irq}, 32'h1);
        wr(A_CTRL, 32'h0);
        wr(A_PEND, 32'hFFFF_FFFF);
        set_code(3, 2'd0);
        pins[3] = 1'b0;
        cyc(4);
        wr(A_PEND, 32'hFFFF_FFFF);

        // R11: unimplemented pins
        wr(A_MASK, 32'hFFFF_FFFF);
        rd(A_MASK, rv); chk("R11 mask width", rv, 32'h3FFF_FFFF);
        pins[31] = 1'b1;
        cyc(5);
        rd(A_PEND, rv); chk("R11 pin 31 silent", rv, 32'h0);
        pins[31] = 1'b0;
        wr(A_MASK, 32'h0);

        // R5: type word readback
        wr(A_THI, 32'h0000_000C);
        rd(A_THI, rv); chk("R5 high word", rv, 32'h0000_000C);
        rd(A_TLO, rv); chk("R5 low word", rv, 32'h0);

        // R1: reset in the middle of a run
        wr(A_MASK, 32'h5);
        wr(A_CTRL, 32'h6);
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
        rd(A_MASK, rv); chk("R1 mask after reset", rv, 32'h0);
        rd(A_CTRL, rv); chk("R1 ctrl after reset", rv, 32'h0);
        rd(A_THI, rv);  chk("R1 type after reset", rv, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule